// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the integer execute stage of a register-based processor. Each cycle it takes a 4-bit operation code, two 32-bit operands, the current condition flags, the carry bit left by the operand shifter and a flag-update control. From these it produces a result, a write enable for the destination register and the next value of the four condition flags. The four flags are negative, zero, carry and overflow. Operand B arrives already shifted. Multiply, memory access and condition evaluation are handled elsewhere.

The operations fall into four groups:
- Moves: plain and inverted.
- Logical operations: AND, OR, XOR and bit-clear.
- Arithmetic: add and subtract with and without carry-in, plus the reverse subtracts that take A from B.
- Compare and test: four forms that only affect the flags.

All outputs are registered, so they appear one clock after the inputs are presented.

Top module: `alu_dp`

## Requirements
- R1: Opcode 0x0 (move) gives B and opcode 0x1 (move-inverted) gives the bitwise NOT of B; both assert the write enable.
- R2: Opcodes 0x2 AND, 0x3 OR, 0x4 XOR and 0x5 bit-clear give A&B, A|B, A^B and A&~B. For example, bit-clear of A=0x11111111 with B=0x01100101 gives 0x10011010.
- R3: Opcode 0x6 gives A+B and opcode 0x7 gives A+B+C, where C is the incoming carry flag. Results wrap modulo 2^32.
- R4: Opcode 0x8 gives A-B and 0x9 gives A-B-NOT(C). Opcode 0xA gives B-A and 0xB gives B-A-NOT(C).
- R5: For arithmetic operations with flag update, carry is the unsigned carry out of an addition. For a subtraction, carry is 1 when no borrow occurs and 0 when a borrow occurs. So 5-3 gives C=1 and 3-5 gives C=0.
- R6: For arithmetic operations with flag update, overflow is set exactly when the signed result of the add or subtract does not fit in 32 bits.
- R7: Opcodes 0xC, 0xD, 0xE and 0xF compute A-B, A+B, A&B and A^B. They deassert the write enable and may change only the flags. The result output still carries the computed value.
- R8: When the flag-update control is low, the next flags equal the incoming flags for every opcode.
- R9: With flag update, moves set N and Z and pass C and V through unchanged. A move of zero gives Z=1 and N=0.
- R10: With flag update, the logical and test operations (0x2 to 0x5, 0xE, 0xF) take C from the shifter carry input and keep V.
- R11: With flag update, N is bit 31 of the computed value and Z is 1 exactly when all of its bits are zero.
- R12: Outputs change one clock after the inputs. During reset the result, the write enable and the flags are all zero. The flag bus is packed as {N,Z,C,V}, with N at bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_in | input | 4 | Operation code |
| a_in | input | 32 | Operand A |
| b_in | input | 32 | Operand B, already shifted |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| set_flags | input | 1 | Flag-update control |
| shift_carry | input | 1 | Carry out of the operand shifter |
| res | output | 32 | Computed value |
| res_we | output | 1 | Destination write enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
Some rules are checked by assertions on every cycle. These cover:
- the flag hold when the update control is low;
- the suppressed write for compare and test operations;
- carry and overflow passing through on moves;
- the shifter carry feeding C on logical operations;
- N and Z agreeing with the registered result.

The arithmetic itself can only be shown by the bench's sweep. This includes the carry/borrow convention, signed overflow, the reverse subtracts and the use of the incoming carry. The sweep covers every opcode against boundary operands and compares each result with a reference model built from signed and unsigned integer arithmetic.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;

  typedef enum logic [3:0] {
    OP_MOV = 4'h0,
    OP_MVN = 4'h1,
    OP_AND = 4'h2,
    OP_OR  = 4'h3,
    OP_XOR = 4'h4,
    OP_BIC = 4'h5,
    OP_ADD = 4'h6,
    OP_ADC = 4'h7,
    OP_SUB = 4'h8,
    OP_SBC = 4'h9,
    OP_RSB = 4'hA,
    OP_RSC = 4'hB,
    OP_CMP = 4'hC,
    OP_CMN = 4'hD,
    OP_TST = 4'hE,
    OP_TEQ = 4'hF
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // flag-update class of an operation
  typedef enum logic [1:0] {
    FC_MOVE  = 2'd0,
    FC_LOGIC = 2'd1,
    FC_ARITH = 2'd2
  } fclass_e;

  function automatic logic op_is_cmp(op_e op);
    return op inside {OP_CMP, OP_CMN, OP_TST, OP_TEQ};
  endfunction

  function automatic fclass_e op_class(op_e op);
    fclass_e fc;
    case (op)
      OP_MOV, OP_MVN: fc = FC_MOVE;
      OP_ADD, OP_ADC, OP_SUB, OP_SBC,
      OP_RSB, OP_RSC, OP_CMP, OP_CMN: fc = FC_ARITH;
      default: fc = FC_LOGIC;
    endcase
    return fc;
  endfunction

endpackage

// File: rtl/alu_dp_arith.sv
module alu_dp_arith
  import alu_dp_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         v_out
);

  // x + y + ci, returning {carry, sum}
  function automatic logic [W:0] add_ext(logic [W-1:0] x, logic [W-1:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  // signed overflow of x + y producing s
  function automatic logic ovf(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] s);
    return (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
  endfunction

  logic [W-1:0] x_opd;
  logic [W-1:0] y_opd;
  logic         ci;
  logic [W:0]   ext;

  // subtraction is done as x + ~y + 1, so carry out means "no borrow"
  always_comb begin
    x_opd = a;
    y_opd = b;
    ci    = 1'b0;
    case (op)
      OP_ADC:         ci = cin;
      OP_SUB, OP_CMP: begin y_opd = ~b; ci = 1'b1; end
      OP_SBC:         begin y_opd = ~b; ci = cin;  end
      OP_RSB:         begin x_opd = b; y_opd = ~a; ci = 1'b1; end
      OP_RSC:         begin x_opd = b; y_opd = ~a; ci = cin;  end
      default:        ci = 1'b0;
    endcase
  end

  assign ext   = add_ext(x_opd, y_opd, ci);
  assign sum   = ext[W-1:0];
  assign c_out = ext[W];
  assign v_out = ovf(x_opd, y_opd, ext[W-1:0]);

endmodule

// File: rtl/alu_dp_logic.sv
module alu_dp_logic
  import alu_dp_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] value
);

  always_comb begin
    case (op)
      OP_MOV:         value = b;
      OP_MVN:         value = ~b;
      OP_AND, OP_TST: value = a & b;
      OP_OR:          value = a | b;
      OP_XOR, OP_TEQ: value = a ^ b;
      OP_BIC:         value = a & ~b;
      default:        value = '0;
    endcase
  end

endmodule

// File: rtl/alu_dp_flags.sv
module alu_dp_flags
  import alu_dp_pkg::*;
#(
  parameter int W = 32
) (
  input  fclass_e      fclass,
  input  logic         set_flags,
  input  logic [W-1:0] value,
  input  nzcv_t        cur,
  input  logic         shift_carry,
  input  logic         arith_c,
  input  logic         arith_v,
  output nzcv_t        nxt
);

  always_comb begin
    nxt = cur;
    if (set_flags) begin
      nxt.n = value[W-1];
      nxt.z = (value == '0);
      case (fclass)
        FC_LOGIC: nxt.c = shift_carry;
        FC_ARITH: begin
          nxt.c = arith_c;
          nxt.v = arith_v;
        end
        default: nxt.c = cur.c;
      endcase
    end
  end

endmodule

// File: rtl/alu_dp.sv
module alu_dp
  import alu_dp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_in,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [3:0]   flags_in,
  input  logic         set_flags,
  input  logic         shift_carry,
  output logic [W-1:0] res,
  output logic         res_we,
  output logic [3:0]   flags_out
);

  op_e          op;
  nzcv_t        cur;
  nzcv_t        nxt;
  fclass_e      fclass;
  logic         cmp_w;
  logic         move_w;
  logic         logic_w;
  logic [W-1:0] sum_w;
  logic         arith_c;
  logic         arith_v;
  logic [W-1:0] logic_val;
  logic [W-1:0] value;
  logic         primed;

  assign op      = op_e'(op_in);
  assign cur     = nzcv_t'(flags_in);
  assign fclass  = op_class(op);
  assign cmp_w   = op_is_cmp(op);
  assign move_w  = (fclass == FC_MOVE);
  assign logic_w = (fclass == FC_LOGIC);

  alu_dp_arith #(.W(W)) u_arith (
    .op    (op),
    .a     (a_in),
    .b     (b_in),
    .cin   (cur.c),
    .sum   (sum_w),
    .c_out (arith_c),
    .v_out (arith_v)
  );

  alu_dp_logic #(.W(W)) u_logic (
    .op    (op),
    .a     (a_in),
    .b     (b_in),
    .value (logic_val)
  );

  assign value = (fclass == FC_ARITH) ? sum_w : logic_val;

  alu_dp_flags #(.W(W)) u_flags (
    .fclass      (fclass),
    .set_flags   (set_flags),
    .value       (value),
    .cur         (cur),
    .shift_carry (shift_carry),
    .arith_c     (arith_c),
    .arith_v     (arith_v),
    .nxt         (nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res       <= '0;
      res_we    <= 1'b0;
      flags_out <= '0;
      primed    <= 1'b0;
    end else begin
      res       <= value;
      res_we    <= !cmp_w;
      flags_out <= nxt;
      primed    <= 1'b1;
    end
  end

  // R8: flags hold when no update requested
  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !$past(set_flags) |-> flags_out == $past(flags_in));

  // R7: compare/test never writes
  a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(cmp_w) |-> !res_we);

  // R12: everything else writes
  a_r12_we: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !$past(cmp_w) |-> res_we);

  // R9: moves keep C and V
  a_r9_move_cv: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(set_flags && move_w) |-> flags_out[1:0] == $past(flags_in[1:0]));

  // R10: logical ops take C from the shifter and keep V
  a_r10_logic_c: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(set_flags && logic_w) |->
      flags_out[1] == $past(shift_carry) && flags_out[0] == $past(flags_in[0]));

  // R11: N and Z follow the registered value
  a_r11_nz: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(set_flags) |->
      flags_out[3] == res[W-1] && flags_out[2] == (res == '0));

endmodule

// File: tb/test_alu_dp.sv
module test_alu_dp;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_in = '0;
  logic [31:0] a_in = '0;
  logic [31:0] b_in = '0;
  logic [3:0]  flags_in = '0;
  logic        set_flags = 1'b0;
  logic        shift_carry = 1'b0;
  logic [31:0] res;
  logic        res_we;
  logic [3:0]  flags_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_dp i_alu_dp (
    .clk(clk), .rst_n(rst_n), .op_in(op_in), .a_in(a_in), .b_in(b_in),
    .flags_in(flags_in), .set_flags(set_flags), .shift_carry(shift_carry),
    .res(res), .res_we(res_we), .flags_out(flags_out)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%h a=%h b=%h f=%b sf=%b sc=%b actual=%h expected=%h",
               req, what, op_in, a_in, b_in, flags_in, set_flags, shift_carry, act, exp);
    end
  endtask

  function automatic logic ovf_s(longint s);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  // Reference: returns {we, N, Z, C, V, result}
  function automatic logic [36:0] model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                        logic [3:0] f, logic sf, logic sc);
    longint ua, ub, sa, sb, t, s;
    logic [31:0] r;
    logic c, v, we, n, z, cin;
    int cls; // 0 move, 1 logic, 2 arith
    ua = longint'({32'd0, a}); ub = longint'({32'd0, b});
    sa = longint'(signed'(a)); sb = longint'(signed'(b));
    cin = f[1]; c = f[1]; v = f[0]; we = 1'b1; cls = 1; r = '0;
    case (op)
      4'h0: begin r = b; cls = 0; end
      4'h1: begin r = ~b; cls = 0; end
      4'h2, 4'hE: r = a & b;
      4'h3: r = a | b;
      4'h4, 4'hF: r = a ^ b;
      4'h5: r = a & ~b;
      4'h6, 4'h7, 4'hD: begin
        t = ua + ub + ((op == 4'h7) ? longint'(cin) : 0);
        s = sa + sb + ((op == 4'h7) ? longint'(cin) : 0);
        r = t[31:0]; c = (t > 64'd4294967295); v = ovf_s(s); cls = 2;
      end
      4'h8, 4'h9, 4'hC: begin
        t = (op == 4'h9) ? longint'(!cin) : 0;
        r = 32'(ua - ub - t); c = (ua >= ub + t); v = ovf_s(sa - sb - t); cls = 2;
      end
      default: begin // 0xA, 0xB reverse
        t = (op == 4'hB) ? longint'(!cin) : 0;
        r = 32'(ub - ua - t); c = (ub >= ua + t); v = ovf_s(sb - sa - t); cls = 2;
      end
    endcase
    if (op >= 4'hC) we = 1'b0;
    if (!sf) return {we, f, r};
    n = r[31]; z = (r == 0);
    if (cls == 0) begin c = f[1]; v = f[0]; end
    else if (cls == 1) begin c = sc; v = f[0]; end
    return {we, n, z, c, v, r};
  endfunction

  function automatic string res_req(logic [3:0] op);
    if (op <= 4'h1) return "R1";
    if (op <= 4'h5) return "R2";
    if (op <= 4'h7) return "R3";
    if (op <= 4'hB) return "R4";
    return "R7";
  endfunction

  task automatic apply_check(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                             logic [3:0] f, logic sf, logic sc);
    logic [36:0] e;
    op_in = op; a_in = a; b_in = b; flags_in = f; set_flags = sf; shift_carry = sc;
    e = model(op, a, b, f, sf, sc);
    @(posedge clk); #1;
    check(res_req(op), "result", 64'(res), 64'(e[31:0]));
    check((op >= 4'hC) ? "R7" : "R12", "write-enable", 64'(res_we), 64'(e[36]));
    if (!sf) check("R8", "flags", 64'(flags_out), 64'(e[35:32]));
    else begin
      check("R11", "N/Z", 64'(flags_out[3:2]), 64'(e[35:34]));
      if (op <= 4'h1)
        check("R9", "C/V", 64'(flags_out[1:0]), 64'(e[33:32]));
      else if (op <= 4'h5 || op >= 4'hE)
        check("R10", "C/V", 64'(flags_out[1:0]), 64'(e[33:32]));
      else begin
        check("R5", "C", 64'(flags_out[1]), 64'(e[33]));
        check("R6", "V", 64'(flags_out[0]), 64'(e[32]));
      end
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R12 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] vals [8];
    logic [3:0] fpat [4];
    vals = '{32'h0, 32'h1, 32'h3, 32'h5, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h11111111};
    fpat = '{4'b0000, 4'b0010, 4'b1101, 4'b0111};

    repeat (3) @(posedge clk);
    #1;
    check("R12", "reset result", 64'(res), 64'd0);
    check("R12", "reset we", 64'(res_we), 64'd0);
    check("R12", "reset flags", 64'(flags_out), 64'd0);
    rst_n = 1'b1;

    // directed cases
    apply_check(4'h5, 32'h11111111, 32'h01100101, 4'b0000, 1'b1, 1'b0); // R2 bit-clear
    check("R2", "bic example", 64'(res), 64'h10011010);
    apply_check(4'h8, 32'd5, 32'd3, 4'b0000, 1'b1, 1'b0);               // R5 no borrow
    check("R5", "5-3 carry", 64'(flags_out[1]), 64'd1);
    apply_check(4'h8, 32'd3, 32'd5, 4'b0010, 1'b1, 1'b0);               // R5 borrow
    check("R5", "3-5 carry", 64'(flags_out[1]), 64'd0);
    apply_check(4'h0, 32'hDEAD, 32'd0, 4'b1011, 1'b1, 1'b0);            // R9 move zero
    check("R9", "move zero flags", 64'(flags_out), 64'b0111);
    apply_check(4'h6, 32'h7FFFFFFF, 32'h1, 4'b0000, 1'b1, 1'b0);        // R6 overflow
    check("R6", "max+1 overflow", 64'(flags_out[0]), 64'd1);

    // sweep
    for (int op = 0; op < 16; op++)
      for (int sf = 0; sf < 2; sf++)
        for (int fi = 0; fi < 4; fi++)
          for (int sc = 0; sc < 2; sc++)
            for (int ia = 0; ia < 8; ia++)
              for (int ib = 0; ib < 8; ib++)
                apply_check(4'(op), vals[ia], vals[ib], fpat[fi], 1'(sf), 1'(sc));

    done = 1;
    finish_run();
  end

endmodule